// File: doc/BRIEF.md
# Phase-Shifted Two-Leg PWM Generator

This block drives the four gates of a fixed-frequency converter built from two complementary switch pairs. Leg A (gates `gate_p1` / `gate_n1`) runs a programmable duty count. Leg B (gates `gate_p2` / `gate_n2`) is always split half and half over the period. Its high-side turn-on is delayed from leg A's turn-on by a programmable phase count. Every transition inside a pair is separated by a deadtime of programmable length, during which both gates of that pair are low.

The period, duty, phase and deadtime settings are sampled continuously at the inputs. They are clamped to a safe range and copied into shadow registers only at a period boundary. A closed-loop controller can therefore change them in any cycle without ever producing a torn period. After reset all gates stay low until the first full period has started.

Top module: `pshift_pwm`

## Requirements
- R1: While `rst_n` is low, and in the first two clock cycles after it is released, all four gate outputs are 0. After an `rst_n` low pulse in mid-run, the same quiet start follows.
- R2: An internal count runs 0, 1, …, PER-1 and then wraps to 0, where PER is the clamped shadow period. Each gate output is registered and shows the state for count c one clock after that count.
- R3: `gate_p1` is 1 exactly for counts c with DT ≤ c < DUTY.
- R4: `gate_n1` is 1 exactly for counts c with c ≥ DUTY + DT. This places a DT-count gap after each turn-off in leg A.
- R5: Let rel = (c − PHASE) mod PER and HALF = floor(PER/2). `gate_p2` is 1 exactly when DT ≤ rel < HALF. The window wraps through count 0 when PHASE + HALF exceeds PER.
- R6: `gate_n2` is 1 exactly when rel ≥ HALF + DT, using the same rel and HALF as R5. For an odd PER, the low-side half is one count longer than the high-side half.
- R7: Input values are copied to the shadow registers only on the cycle that leaves count PER-1, and on the first cycle after reset. A change at any other count has no effect on the gates until the next period begins.
- R8: DUTY = min(max(`duty_i`, DT), PER − DT). This guarantees a nominal on-window of at least DT for both gates of leg A.
- R9: PHASE = `phase_i` when it is below PER. Otherwise PHASE = PER − 1.
- R10: PER = max(`period_i`, 4). DT = min(`dead_i`, HALF − 1).
- R11: The two gates of a pair are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | 8 | Requested period length in clock counts |
| duty_i | input | 8 | Requested turn-off count of gate_p1 |
| phase_i | input | 8 | Requested delay from leg A turn-on to leg B turn-on, in counts |
| dead_i | input | 8 | Requested deadtime in counts |
| gate_p1 | output | 1 | Leg A high-side gate |
| gate_n1 | output | 1 | Leg A low-side gate |
| gate_p2 | output | 1 | Leg B high-side gate |
| gate_n2 | output | 1 | Leg B low-side gate |

## Verification
Two events can fall in the same cycle: the shadow-register update at the period wrap, and a leg B edge at count 0. The leg B edge lands there when PHASE is 0, or when PHASE + HALF equals PER. The bench sets these phase values while it changes the settings exactly on the last count of a period. It also changes them a few counts into a period. A behavioural model applies the new settings at the wrap and holds the old ones otherwise. The outputs are compared against this model on every clock, so a mistimed update shows up as a gate that differs from the model in that cycle.

// File: rtl/psp_pkg.sv
// Shared width and settings record for the phase-shifted PWM generator.
// Assumes every count fits into PSP_CW bits.
package psp_pkg;
    localparam int PSP_CW = 8;

    typedef logic [PSP_CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t per;    // clamped period
        cnt_t half;   // floor(per/2)
        cnt_t duty;   // clamped leg A turn-off count
        cnt_t phase;  // clamped leg B offset
        cnt_t dt;     // clamped deadtime
    } cfg_t;
endpackage

// File: rtl/psp_shadow.sv
// Clamps the requested settings and holds them in shadow registers.
// Assumes load is asserted only at a period boundary or at start-up.
module psp_shadow
    import psp_pkg::*;
#(
    parameter int MIN_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cnt_t period_i,
    input  cnt_t duty_i,
    input  cnt_t phase_i,
    input  cnt_t dead_i,
    output cfg_t cfg
);
    localparam cnt_t MINP = cnt_t'(MIN_PERIOD);

    cfg_t nxt;
    cnt_t dmax;

    // Combinational clamp of the raw inputs into a consistent setting.
    always_comb begin
        nxt.per  = (period_i < MINP) ? MINP : period_i;
        nxt.half = nxt.per >> 1;
        nxt.dt   = (dead_i > nxt.half - 1'b1) ? nxt.half - 1'b1 : dead_i;
        dmax     = nxt.per - nxt.dt;
        nxt.duty = (duty_i > dmax) ? dmax : duty_i;
        if (nxt.duty < nxt.dt) nxt.duty = nxt.dt;
        nxt.phase = (phase_i >= nxt.per) ? nxt.per - 1'b1 : phase_i;
    end

    // Shadow register: captures the clamped setting on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else if (load) cfg <= nxt;
    end
endmodule

// File: rtl/psp_counter.sv
// Free-running period counter with a start flag.
// Assumes per is at least 1 whenever run is high.
module psp_counter
    import psp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t per,
    output cnt_t cnt,
    output logic run,
    output logic load
);
    // Load request: first active cycle after reset, or the last count of a period.
    assign load = !run || (cnt == per - 1'b1);

    // Count state: wraps to zero on load, otherwise increments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            run <= 1'b1;
            cnt <= load ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psp_leg.sv
// One complementary leg: high side on while dt <= rel < len,
// low side on while rel >= len + dt; both registered.
// Assumes len + dt does not exceed the period.
module psp_leg
    import psp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  cnt_t rel,
    input  cnt_t len,
    input  cnt_t dt,
    output logic hi_o,
    output logic lo_o
);
    logic [PSP_CW:0] lo_start;
    logic            hi_n;
    logic            lo_n;

    // Window decode for both sides of the leg with deadtime applied.
    always_comb begin
        lo_start = {1'b0, len} + {1'b0, dt};
        hi_n     = run && (rel >= dt) && (rel < len);
        lo_n     = run && ({1'b0, rel} >= lo_start);
    end

    // Output registers for the two gates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= 1'b0;
            lo_o <= 1'b0;
        end else begin
            hi_o <= hi_n;
            lo_o <= lo_n;
        end
    end
endmodule

// File: rtl/pshift_pwm.sv
// Phase-shifted two-leg PWM generator. Leg A runs a programmable duty.
// Leg B runs half and half, with its turn-on delayed from leg A by a
// phase count. Settings take effect only at a period boundary.
// Assumes a single clock domain and inputs synchronous to clk.
module pshift_pwm
    import psp_pkg::*;
#(
    parameter int MIN_PERIOD = 4,
    parameter int NUM_LEGS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSP_CW-1:0] period_i,
    input  logic [PSP_CW-1:0] duty_i,
    input  logic [PSP_CW-1:0] phase_i,
    input  logic [PSP_CW-1:0] dead_i,
    output logic             gate_p1,
    output logic             gate_n1,
    output logic             gate_p2,
    output logic             gate_n2
);
    cfg_t cfg;
    cnt_t cnt;
    logic run;
    logic load;
    cnt_t rel [NUM_LEGS];
    cnt_t len [NUM_LEGS];
    logic hi  [NUM_LEGS];
    logic lo  [NUM_LEGS];

    psp_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .per   (cfg.per),
        .cnt   (cnt),
        .run   (run),
        .load  (load)
    );

    psp_shadow #(.MIN_PERIOD(MIN_PERIOD)) u_shd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .period_i (period_i),
        .duty_i   (duty_i),
        .phase_i  (phase_i),
        .dead_i   (dead_i),
        .cfg      (cfg)
    );

    // Per-leg position in period and on-length; leg B is phase-rotated.
    always_comb begin
        rel[0] = cnt;
        len[0] = cfg.duty;
        rel[1] = (cnt >= cfg.phase) ? cnt - cfg.phase
                                    : cnt + (cfg.per - cfg.phase);
        len[1] = cfg.half;
    end

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        psp_leg u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .rel   (rel[k]),
            .len   (len[k]),
            .dt    (cfg.dt),
            .hi_o  (hi[k]),
            .lo_o  (lo[k])
        );
    end

    assign gate_p1 = hi[0];
    assign gate_n1 = lo[0];
    assign gate_p2 = hi[1];
    assign gate_n2 = lo[1];
endmodule

// File: rtl/psp_checker.sv
// Property checker for pshift_pwm, attached by bind.
// Assumes the internal names of the counter and shadow settings.
module psp_checker
    import psp_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic run,
    input cnt_t cnt,
    input cnt_t per_s,
    input cnt_t half_s,
    input cnt_t duty_s,
    input cnt_t phase_s,
    input cnt_t dt_s,
    input logic gate_p1,
    input logic gate_n1,
    input logic gate_p2,
    input logic gate_n2
);
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(gate_p1 || gate_n1 || gate_p2 || gate_n2));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt < per_s);

    a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_n1) && $past(dt_s) != '0) |-> $past(!gate_p1));

    a_r7_hold_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != per_s - 1'b1) |=>
        ($stable(duty_s) && $stable(phase_s) && $stable(dt_s) && $stable(per_s)));

    a_r8_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (duty_s >= dt_s && duty_s <= per_s - dt_s));

    a_r9_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> phase_s < per_s);

    a_r10_dead_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dt_s < half_s && per_s >= 8'd4));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_p1 && gate_n1) && !(gate_p2 && gate_n2));
endmodule

bind pshift_pwm psp_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cnt     (cnt),
    .per_s   (cfg.per),
    .half_s  (cfg.half),
    .duty_s  (cfg.duty),
    .phase_s (cfg.phase),
    .dt_s    (cfg.dt),
    .gate_p1 (gate_p1),
    .gate_n1 (gate_n1),
    .gate_p2 (gate_p2),
    .gate_n2 (gate_n2)
);

// File: tb/sim_pshift_pwm.sv
// Bench for pshift_pwm: behavioural per-cycle model compared on every clock.
module sim_pshift_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] period_i = 8'd20;
    logic [7:0] duty_i = 8'd8;
    logic [7:0] phase_i = 8'd5;
    logic [7:0] dead_i = 8'd2;
    logic       gate_p1, gate_n1, gate_p2, gate_n2;

    always #2 clk = ~clk;   // 4 ns period

    pshift_pwm u0 (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .phase_i(phase_i), .dead_i(dead_i), .gate_p1(gate_p1),
        .gate_n1(gate_n1), .gate_p2(gate_p2), .gate_n2(gate_n2)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    started = 0;
    string tag = "R1";

    // Reference model state
    int m_run = 0, m_cnt = 0;
    int m_per = 4, m_half = 2, m_duty = 0, m_ph = 0, m_dt = 0;
    bit e1 = 0, e2 = 0, e3 = 0, e4 = 0;

    always @(posedge clk) begin
        int rel;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0;
            e1 = 0; e2 = 0; e3 = 0; e4 = 0;
        end else begin
            if (m_run != 0) begin
                rel = (m_cnt - m_ph + m_per) % m_per;
                e1 = (m_cnt >= m_dt) && (m_cnt < m_duty);
                e2 = (m_cnt >= m_duty + m_dt);
                e4 = (rel >= m_dt) && (rel < m_half);
                e3 = (rel >= m_half + m_dt);
            end else begin
                e1 = 0; e2 = 0; e3 = 0; e4 = 0;
            end
            if (m_run == 0 || m_cnt == m_per - 1) begin
                m_run  = 1;
                m_cnt  = 0;
                m_per  = (int'(period_i) < 4) ? 4 : int'(period_i);
                m_half = m_per / 2;
                m_dt   = (int'(dead_i) > m_half - 1) ? m_half - 1 : int'(dead_i);
                m_duty = (int'(duty_i) > m_per - m_dt) ? m_per - m_dt : int'(duty_i);
                if (m_duty < m_dt) m_duty = m_dt;
                m_ph   = (int'(phase_i) >= m_per) ? m_per - 1 : int'(phase_i);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(string req, string name, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] %s act=%b exp=%b t=%0t", req, tag, name, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk(tag == "R1" ? "R1" : "R3", "gate_p1", gate_p1, e1);
            chk(tag == "R1" ? "R1" : "R4", "gate_n1", gate_n1, e2);
            chk(tag == "R1" ? "R1" : "R5", "gate_p2", gate_p2, e4);
            chk(tag == "R1" ? "R1" : "R6", "gate_n2", gate_n2, e3);
        end
    end

    task automatic show_summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog R2 act=%0d exp<=150000", cyc);
            show_summary();
            $finish;
        end
    end

    task automatic run_for(string t, int n, int per, int duty, int ph, int dt);
        @(negedge clk);
        tag = t;
        period_i = 8'(per); duty_i = 8'(duty); phase_i = 8'(ph); dead_i = 8'(dt);
        repeat (n) @(negedge clk);
    endtask

    // Drive a new setting on the negedge just before the wrap edge.
    task automatic change_at_wrap(int per, int duty, int ph, int dt);
        do @(negedge clk); while (m_cnt != m_per - 1);
        period_i = 8'(per); duty_i = 8'(duty); phase_i = 8'(ph); dead_i = 8'(dt);
    endtask

    initial begin
        @(posedge clk);
        started = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;                          // R1: quiet start
        repeat (3) @(negedge clk);
        run_for("R2", 80, 20, 8, 5, 2);        // basic period and windows
        run_for("R3", 60, 20, 12, 3, 1);
        run_for("R5", 80, 20, 8, 15, 2);       // leg B wraps through zero
        run_for("R6", 84, 21, 10, 0, 3);       // odd period, edge at wrap
        // R7: change mid-period (deferred) and exactly at the wrap
        run_for("R7", 4, 16, 6, 8, 2);
        repeat (2) begin
            @(negedge clk);
            duty_i = 8'd2; phase_i = 8'd1; dead_i = 8'd0;
            repeat (20) @(negedge clk);
            change_at_wrap(16, 10, 0, 2);
            repeat (20) @(negedge clk);
            change_at_wrap(24, 9, 12, 3);      // phase + half == period
            repeat (30) @(negedge clk);
        end
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((i % 7) == 0) begin
                period_i = 8'($urandom_range(1, 40));
                duty_i   = 8'($urandom_range(0, 45));
                phase_i  = 8'($urandom_range(0, 50));
                dead_i   = 8'($urandom_range(0, 8));
            end
        end
        run_for("R8", 60, 20, 0, 4, 3);        // duty below deadtime
        run_for("R8", 60, 20, 255, 4, 3);      // duty above PER-DT
        run_for("R9", 60, 20, 9, 200, 2);      // phase beyond period
        run_for("R10", 60, 20, 9, 4, 50);      // deadtime beyond half
        run_for("R10", 40, 1, 2, 1, 0);        // period below minimum
        run_for("R10", 40, 255, 100, 30, 4);   // longest period
        run_for("R11", 30, 10, 5, 2, 0);       // zero deadtime
        @(negedge clk);
        tag = "R1";
        rst_n = 1'b0;                          // R1: reset in mid-run
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_for("R2", 40, 12, 4, 6, 1);
        show_summary();
        $finish;
    end
endmodule